// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block takes one burst descriptor at a time and walks through it, presenting the address of each data beat in turn on a valid/ready output. A descriptor carries a start address, a burst kind, a length code, a transfer size code and a transaction tag. The block computes every beat address itself, so the data path of a bus bridge only has to follow the beat stream.

For each beat the block drives the beat address, the tag captured with the descriptor, and a flag that marks the final beat. It supports three addressing modes:

- **Fixed:** every beat uses the same address.
- **Incrementing:** the address advances by one transfer size per beat.
- **Wrapping:** the offset from the start address folds back modulo (transfer size × length code). The fold is applied to the unaligned start address, not to an aligned wrap boundary.

Output backpressure stalls the sequence without dropping or repeating a beat. A new descriptor is taken only after the last beat of the current one has been handed off.

Top module: `burst_beat_seq`

## Requirements
- R1: A burst with length code L produces exactly L+1 beats, and `beatLast` is 1 on the final beat and 0 on every earlier beat.
- R2: Kind code 0 (fixed) puts every beat at the start address, and the unused kind code 3 behaves exactly like code 0.
- R3: Kind code 1 (incrementing) puts beat i at start + i·2^S, where S is the size code; the sum is taken modulo 2^ADDR_W and wraps silently.
- R4: Kind code 2 (wrapping) puts beat i at start + ((i·2^S) mod (2^S·L)), modulo 2^ADDR_W; with L = 0 the single beat is at the start address.
- R5: `beatId` equals the tag presented with the descriptor on every beat of that burst.
- R6: `descReady` is 1 only while no burst is active. A descriptor is accepted on a cycle where `descValid` and `descReady` are both 1. The first beat is valid on the next cycle, and `descReady` returns to 1 in the cycle after the last beat is handed off.
- R7: While `beatValid` is 1 and `beatReady` is 0, the beat address, tag and last flag hold steady, and the beat is still presented once `beatReady` rises.
- R8: After reset, `descReady` is 1 and `beatValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Descriptor can be taken (idle) |
| descAddr | input | ADDR_W | Start address |
| descKind | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping, 3 treated as fixed |
| descLen | input | LEN_W | Length code (beats minus one) |
| descSize | input | SIZE_W | Size code, bytes per beat = 2^code |
| descId | input | ID_W | Transaction tag |
| beatValid | output | 1 | Beat address presented |
| beatReady | input | 1 | Consumer takes the beat |
| beatAddr | output | ADDR_W | Address of the current beat |
| beatId | output | ID_W | Tag of the current burst |
| beatLast | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with a 12-bit address, a 3-bit length code, a 2-bit size code and a 4-bit tag. With these widths it can sweep every kind code (including the unused one), every length from one to eight beats and every size from 1 to 8 bytes.

Three start addresses are used:
- zero,
- an unaligned middle value, which exposes the unaligned fold of the wrapping mode,
- a value just below the top, which forces silent address overflow in the incrementing and wrapping modes.

Half of the bursts are run with a stall on every other beat, so the hold-under-backpressure behaviour is exercised on all three kinds.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burstKind_e;

  typedef struct packed {
    logic load;     // capture a new descriptor
    logic advance;  // current beat handed off
  } seqStrobe_t;

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_beat_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descValid,
  input  logic [LEN_W-1:0] descLen,
  output logic             descReady,
  input  logic             beatReady,
  output logic             beatValid,
  output logic             beatLast,
  output seqStrobe_t       strobe
);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  seqState_e        state;
  logic [LEN_W-1:0] beatCnt;
  logic [LEN_W-1:0] lenR;

  assign descReady      = (state == ST_IDLE);
  assign beatValid      = (state == ST_RUN);
  assign beatLast       = beatValid && (beatCnt == lenR);
  assign strobe.load    = descValid && descReady;
  assign strobe.advance = beatValid && beatReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      lenR    <= '0;
    end else if (strobe.load) begin
      state   <= ST_RUN;
      beatCnt <= '0;
      lenR    <= descLen;
    end else if (strobe.advance) begin
      if (beatLast) state <= ST_IDLE;
      beatCnt <= beatCnt + 1'b1;
    end
  end

endmodule

// File: rtl/burst_beat_dp.sv
module burst_beat_dp
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [1:0]        descKind,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [SIZE_W-1:0] descSize,
  input  logic [ID_W-1:0]   descId,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [ID_W-1:0]   beatId
);

  // the wrap span (len << size) must fit without loss
  localparam int SPAN_W = LEN_W + (1 << SIZE_W);

  logic [ADDR_W-1:0] startR;
  burstKind_e        kindR;
  logic [LEN_W-1:0]  lenR;
  logic [SIZE_W-1:0] sizeR;
  logic [ID_W-1:0]   idR;
  logic [ADDR_W-1:0] incrOff;
  logic [SPAN_W-1:0] wrapOff;

  logic [SPAN_W-1:0] step;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W:0]   wrapSum;
  logic [SPAN_W-1:0] wrapNext;
  logic [ADDR_W-1:0] offSel;

  assign step    = SPAN_W'(1) << sizeR;
  assign span    = SPAN_W'(lenR) << sizeR;
  assign wrapSum = {1'b0, wrapOff} + {1'b0, step};

  always_comb begin
    if (wrapSum >= {1'b0, span}) wrapNext = SPAN_W'(wrapSum - {1'b0, span});
    else                         wrapNext = SPAN_W'(wrapSum);
  end

  always_comb begin
    case (kindR)
      BK_INCR: offSel = incrOff;
      BK_WRAP: offSel = (lenR == '0) ? '0 : ADDR_W'(wrapOff);
      default: offSel = '0;
    endcase
  end

  assign beatAddr = startR + offSel;
  assign beatId   = idR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR  <= '0;
      kindR   <= BK_FIXED;
      lenR    <= '0;
      sizeR   <= '0;
      idR     <= '0;
      incrOff <= '0;
      wrapOff <= '0;
    end else if (strobe.load) begin
      startR  <= descAddr;
      kindR   <= burstKind_e'(descKind);
      lenR    <= descLen;
      sizeR   <= descSize;
      idR     <= descId;
      incrOff <= '0;
      wrapOff <= '0;
    end else if (strobe.advance) begin
      incrOff <= incrOff + ADDR_W'(step);
      wrapOff <= wrapNext;
    end
  end

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  output logic              descReady,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [1:0]        descKind,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [SIZE_W-1:0] descSize,
  input  logic [ID_W-1:0]   descId,
  output logic              beatValid,
  input  logic              beatReady,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [ID_W-1:0]   beatId,
  output logic              beatLast
);

  seqStrobe_t strobe;

  burst_beat_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .descValid (descValid),
    .descLen   (descLen),
    .descReady (descReady),
    .beatReady (beatReady),
    .beatValid (beatValid),
    .beatLast  (beatLast),
    .strobe    (strobe)
  );

  burst_beat_dp #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .LEN_W  (LEN_W),
    .SIZE_W (SIZE_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .descAddr (descAddr),
    .descKind (descKind),
    .descLen  (descLen),
    .descSize (descSize),
    .descId   (descId),
    .beatAddr (beatAddr),
    .beatId   (beatId)
  );

endmodule

// File: rtl/burst_beat_seq_chk.sv
module burst_beat_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              descValid,
  input logic              descReady,
  input logic [ADDR_W-1:0] descAddr,
  input logic [1:0]        descKind,
  input logic [LEN_W-1:0]  descLen,
  input logic [SIZE_W-1:0] descSize,
  input logic [ID_W-1:0]   descId,
  input logic              beatValid,
  input logic              beatReady,
  input logic [ADDR_W-1:0] beatAddr,
  input logic [ID_W-1:0]   beatId,
  input logic              beatLast
);

  logic [1:0]        kindQ;
  logic [LEN_W-1:0]  lenQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [ID_W-1:0]   idQ;
  logic [LEN_W-1:0]  seenCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= '0; lenQ <= '0; sizeQ <= '0; idQ <= '0; seenCnt <= '0;
    end else if (descValid && descReady) begin
      kindQ <= descKind; lenQ <= descLen; sizeQ <= descSize; idQ <= descId;
      seenCnt <= '0;
    end else if (beatValid && beatReady) begin
      seenCnt <= seenCnt + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rstN) |-> descReady && !beatValid); // R8

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(descReady && beatValid)); // R6

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady |=> beatValid && beatAddr == $past(descAddr)); // R6

  AST_LAST_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (beatLast == (seenCnt == lenQ))); // R1

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && !beatLast && (kindQ == 2'd0 || kindQ == 2'd3)
      |=> beatAddr == $past(beatAddr)); // R2

  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && !beatLast && kindQ == 2'd1
      |=> beatAddr == $past(beatAddr) + (ADDR_W'(1) << $past(sizeQ))); // R3

  AST_ID_PASS: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> beatId == idQ); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=> beatValid && $stable(beatAddr)
      && $stable(beatId) && $stable(beatLast)); // R7

endmodule

bind burst_beat_seq burst_beat_seq_chk #(
  .ADDR_W (ADDR_W),
  .ID_W   (ID_W),
  .LEN_W  (LEN_W),
  .SIZE_W (SIZE_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .descValid (descValid),
  .descReady (descReady),
  .descAddr  (descAddr),
  .descKind  (descKind),
  .descLen   (descLen),
  .descSize  (descSize),
  .descId    (descId),
  .beatValid (beatValid),
  .beatReady (beatReady),
  .beatAddr  (beatAddr),
  .beatId    (beatId),
  .beatLast  (beatLast)
);

// File: tb/sim_burst_beat_seq.sv
module sim_burst_beat_seq;

  localparam int ADDR_W = 12;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 3;
  localparam int SIZE_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              descValid = 1'b0;
  logic              descReady;
  logic [ADDR_W-1:0] descAddr = '0;
  logic [1:0]        descKind = '0;
  logic [LEN_W-1:0]  descLen = '0;
  logic [SIZE_W-1:0] descSize = '0;
  logic [ID_W-1:0]   descId = '0;
  logic              beatValid;
  logic              beatReady = 1'b1;
  logic [ADDR_W-1:0] beatAddr;
  logic [ID_W-1:0]   beatId;
  logic              beatLast;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  burst_beat_seq #(
    .ADDR_W (ADDR_W), .ID_W (ID_W), .LEN_W (LEN_W), .SIZE_W (SIZE_W)
  ) u0 (
    .clk (clk), .rstN (rstN),
    .descValid (descValid), .descReady (descReady),
    .descAddr (descAddr), .descKind (descKind), .descLen (descLen),
    .descSize (descSize), .descId (descId),
    .beatValid (beatValid), .beatReady (beatReady),
    .beatAddr (beatAddr), .beatId (beatId), .beatLast (beatLast)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expAddr(int start, int kind, int len, int size, int i);
    int off;
    off = i << size;
    if (kind == 1)                  return (start + off) % (1 << ADDR_W);
    if (kind == 2 && len != 0)      return (start + (off % (len << size))) % (1 << ADDR_W);
    return start;
  endfunction

  task automatic runBurst(input int start, input int kind, input int len,
                          input int size, input int id, input bit stall);
    string aTag;
    aTag = (kind == 1) ? "R3 incr addr" : (kind == 2) ? "R4 wrap addr" : "R2 fixed addr";
    @(negedge clk);
    chk(descReady == 1'b1, "R6 ready when idle", int'(descReady), 1);
    descValid = 1'b1;
    descAddr  = ADDR_W'(start);
    descKind  = 2'(kind);
    descLen   = LEN_W'(len);
    descSize  = SIZE_W'(size);
    descId    = ID_W'(id);
    @(posedge clk);
    @(negedge clk);
    descValid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      chk(beatValid == 1'b1, "R1 beat present", int'(beatValid), 1);
      chk(descReady == 1'b0, "R6 busy blocks desc", int'(descReady), 0);
      chk(int'(beatAddr) == expAddr(start, kind, len, size, i), aTag,
          int'(beatAddr), expAddr(start, kind, len, size, i));
      chk(int'(beatId) == id, "R5 id", int'(beatId), id);
      chk(beatLast == (i == len), "R1 last flag", int'(beatLast), int'(i == len));
      if (stall && (i % 2 == 0)) begin
        beatReady = 1'b0;
        @(negedge clk);
        chk(beatValid && int'(beatAddr) == expAddr(start, kind, len, size, i),
            "R7 stall hold addr", int'(beatAddr), expAddr(start, kind, len, size, i));
        chk(beatLast == (i == len), "R7 stall hold last", int'(beatLast), int'(i == len));
        beatReady = 1'b1;
      end
      @(negedge clk);
    end
    chk(beatValid == 1'b0, "R1 no extra beat", int'(beatValid), 0);
    chk(descReady == 1'b1, "R6 ready after last", int'(descReady), 1);
  endtask

  initial begin
    int starts[3];
    starts[0] = 'h000;
    starts[1] = 'h5A3;
    starts[2] = 'hFF9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(descReady == 1'b1, "R8 reset ready", int'(descReady), 1);
    chk(beatValid == 1'b0, "R8 reset valid", int'(beatValid), 0);
    rstN = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++)
        for (int l = 0; l < 8; l++)
          for (int z = 0; z < 4; z++)
            runBurst(starts[s], k, l, z, (s * 5 + k + l + z) % 16, ((l + z) % 2) == 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule